// File: doc/BRIEF.md
# Configurable I/O Port Synchronizer

This block joins a routing fabric to an eight-pin bidirectional port. Each pin has three paths. Output data comes from the fabric. Input data goes back to the fabric. A per-pin drive enable decides whether the block drives the pad or releases it to high impedance, so the same pin can be shared as a bus line with another driver.

Two static configuration vectors set, pin by pin, how each path is timed. When a pin's output-register bit is set, its outgoing data and its drive enable are captured together on the system clock. Both then reach the pad on the same edge. When the bit is clear, both pass straight through. When a pin's input-synchronizer bit is set, the pad value reaches the fabric through two flops. When it is clear, the pad value passes straight through, so a signal can travel from pad to fabric and back out with no register in the way.

The fabric supplies only four drive-enable lines. A two-bit grouping selector spreads these four lines over the eight pins. The selector ranges from one line that gates the whole port to four individually gated pins.

Top module: `iosync_port`

## Requirements
- R1: While reset is asserted (`rst_n` low), all internal flops are held at 0. Every pin with its output register selected is therefore released (not driven), and every pin with its input synchronizer selected shows 0 to the fabric.
- R2: With `cfg_out_reg[i]`=1, the pad's driven value and its drive enable both take the values that `fab_do[i]` and the pin's mapped enable had before the previous rising clock edge. Data and enable change on the same edge.
- R3: With `cfg_out_reg[i]`=0, the pad is driven combinationally from `fab_do[i]` and the pin's mapped enable, with no clock delay.
- R4: With `cfg_in_sync[i]`=1, `fab_di[i]` equals the pad value sampled two rising clock edges earlier.
- R5: With `cfg_in_sync[i]`=0, `fab_di[i]` follows the pad combinationally.
- R6: Grouping code 0 (`cfg_oe_mode`=2'd0): `fab_oe[0]` enables all eight pins.
- R7: Grouping code 1: `fab_oe[0]` enables pins 0 to 3, and `fab_oe[1]` enables pins 4 to 7.
- R8: Grouping code 2: `fab_oe[k]` enables pins 2k and 2k+1.
- R9: Grouping code 3: `fab_oe[k]` enables pin k for k = 0 to 3, and pins 4 to 7 are always enabled.
- R10: A pin whose effective enable is 0 does not drive its pad. Another driver's value is then seen on the pad and on the input path.
- R11: Reset is applied at once but released in step with the clock. After `rst_n` rises, the flops stay at 0 through the first two rising edges and update from the third edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used for every register |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cfg_out_reg | input | 8 | Per-pin select: 1 registers the output data and enable |
| cfg_in_sync | input | 8 | Per-pin select: 1 routes the input through two flops |
| cfg_oe_mode | input | 2 | Grouping of the four enable lines onto the pins (codes 0 to 3) |
| fab_do | input | 8 | Output data from the fabric, one bit per pin |
| fab_oe | input | 4 | Drive-enable lines from the fabric |
| fab_di | output | 8 | Input data to the fabric, one bit per pin |
| pad | inout | 8 | Tri-state pins |

## Verification
The bench builds the block with its default sizes: eight pins, four enable lines and a two-flop input chain. With these sizes every grouping code has its full meaning, including the four always-enabled upper pins of code 3. The reference model follows each pin on every clock while random data and enables sweep all four grouping codes. The configuration vectors are swept across all-bypass, all-registered and mixed per-pin patterns (0x5A out, 0xC3 in). The bench drives each pad with the inverse of the expected block data, so the pad value shows at once which side is driving. A reset pulse in the middle of the run, away from any edge, brings the asynchronous clear and the two-edge release within reach.

// File: rtl/iosync_pkg.sv
package iosync_pkg;
  typedef enum logic [1:0] {
    OE_GANG_ALL  = 2'd0,
    OE_GANG_HALF = 2'd1,
    OE_GANG_PAIR = 2'd2,
    OE_PER_PIN   = 2'd3
  } oe_map_e;
endpackage

// File: rtl/iosync_rst_sync.sv
module iosync_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_nxt;
  end

  assign rst_o = chain_q[STAGES-1];

  // R11: internal reset leaves only after the input has been high across an edge
  p_sync_release_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(rst_ni));
endmodule

// File: rtl/iosync_oe_map.sv
module iosync_oe_map
  import iosync_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NOE   = 4
) (
  input  oe_map_e          mode,
  input  logic [NOE-1:0]   oe_lines,
  output logic [NPINS-1:0] pin_en
);
  localparam int HALF = NPINS / 2;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int IDX_H = ((i / HALF) < NOE) ? (i / HALF) : (NOE - 1);
    localparam int IDX_P = ((i / 2) < NOE) ? (i / 2) : (NOE - 1);
    logic single_en;
    if (i < NOE) begin : g_own
      assign single_en = oe_lines[i];
    end else begin : g_fixed
      assign single_en = 1'b1;
    end

    always_comb begin
      unique case (mode)
        OE_GANG_ALL:  pin_en[i] = oe_lines[0];
        OE_GANG_HALF: pin_en[i] = oe_lines[IDX_H];
        OE_GANG_PAIR: pin_en[i] = oe_lines[IDX_P];
        default:      pin_en[i] = single_en;
      endcase
    end
  end

  // R6: one shared line means every pin agrees
  always_comb begin
    if (mode == OE_GANG_ALL)
      p_gang_all_r6: assert ($countones(pin_en) == 0 || $countones(pin_en) == NPINS);
  end

  if (NPINS > NOE) begin : g_chk_upper
    // R9: pins without a line of their own stay enabled
    always_comb begin
      if (mode == OE_PER_PIN)
        p_upper_on_r9: assert (&pin_en[NPINS-1:NOE]);
    end
  end
endmodule

// File: rtl/iosync_out_stage.sv
module iosync_out_stage #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cfg_reg,
  input  logic [NPINS-1:0] d_in,
  input  logic [NPINS-1:0] en_in,
  output logic [NPINS-1:0] d_out,
  output logic [NPINS-1:0] en_out
);
  logic [NPINS-1:0] d_q, en_q, d_nxt, en_nxt;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    // next state: load when this pin's register is selected, else hold
    always_comb begin
      d_nxt[i]  = cfg_reg[i] ? d_in[i]  : d_q[i];
      en_nxt[i] = cfg_reg[i] ? en_in[i] : en_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[i]  <= 1'b0;
        en_q[i] <= 1'b0;
      end else begin
        d_q[i]  <= d_nxt[i];
        en_q[i] <= en_nxt[i];
      end
    end

    assign d_out[i]  = cfg_reg[i] ? d_q[i]  : d_in[i];
    assign en_out[i] = cfg_reg[i] ? en_q[i] : en_in[i];

    // R2: data and enable both lag their inputs by exactly one edge
    p_reg_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && cfg_reg[i] && $past(cfg_reg[i])) |->
        (d_out[i] == $past(d_in[i]) && en_out[i] == $past(en_in[i])));
  end
endmodule

// File: rtl/iosync_in_sync.sv
module iosync_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cfg_sync,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] fab_out
);
  logic [STAGES-1:0] chain_q   [NPINS];
  logic [STAGES-1:0] chain_nxt [NPINS];

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_comb begin
      chain_nxt[i] = cfg_sync[i] ? {chain_q[i][STAGES-2:0], pad_in[i]} : chain_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= '0;
      else        chain_q[i] <= chain_nxt[i];
    end

    assign fab_out[i] = cfg_sync[i] ? chain_q[i][STAGES-1] : pad_in[i];

    if (STAGES == 2) begin : g_chk
      // R4: synchronized path shows the pad from two edges back
      p_two_edge_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && cfg_sync[i] && $past(cfg_sync[i])
         && $past(cfg_sync[i], 2)) |-> (fab_out[i] == $past(pad_in[i], 2)));
    end
  end
endmodule

// File: rtl/iosync_port.sv
module iosync_port
  import iosync_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int NOE      = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cfg_out_reg,
  input  logic [NPINS-1:0] cfg_in_sync,
  input  logic [1:0]       cfg_oe_mode,
  input  logic [NPINS-1:0] fab_do,
  input  logic [NOE-1:0]   fab_oe,
  output logic [NPINS-1:0] fab_di,
  inout  wire  [NPINS-1:0] pad
);
  logic             rst_int_n;
  logic [NPINS-1:0] map_en;
  logic [NPINS-1:0] drv_val;
  logic [NPINS-1:0] drv_en;
  logic [NPINS-1:0] pad_in;

  iosync_rst_sync #(.STAGES(2)) i_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_o  (rst_int_n)
  );

  iosync_oe_map #(.NPINS(NPINS), .NOE(NOE)) i_map (
    .mode     (oe_map_e'(cfg_oe_mode)),
    .oe_lines (fab_oe),
    .pin_en   (map_en)
  );

  iosync_out_stage #(.NPINS(NPINS)) i_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cfg_reg (cfg_out_reg),
    .d_in    (fab_do),
    .en_in   (map_en),
    .d_out   (drv_val),
    .en_out  (drv_en)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    assign pad[i]    = drv_en[i] ? drv_val[i] : 1'bz;
    assign pad_in[i] = pad[i];

    // R3: a bypassed pin drives exactly what the fabric presents this cycle
    p_bypass_out_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
      !cfg_out_reg[i] |-> (drv_en[i] == map_en[i] && drv_val[i] == fab_do[i]));
  end

  iosync_in_sync #(.NPINS(NPINS), .STAGES(SYNC_LEN)) i_in (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_sync (cfg_in_sync),
    .pad_in   (pad_in),
    .fab_out  (fab_di)
  );
endmodule

// File: tb/test_iosync_port.sv
module test_iosync_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_out_reg, cfg_in_sync, fab_do;
  logic [1:0] cfg_oe_mode;
  logic [3:0] fab_oe;
  logic [7:0] fab_di;
  wire  [7:0] pad;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  iosync_port i_iosync_port (
    .clk(clk), .rst_n(rst_n), .cfg_out_reg(cfg_out_reg), .cfg_in_sync(cfg_in_sync),
    .cfg_oe_mode(cfg_oe_mode), .fab_do(fab_do), .fab_oe(fab_oe),
    .fab_di(fab_di), .pad(pad)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_dq, m_eq, m_s1, m_s2;
  int         rel_cnt;
  logic [7:0] m_map, e_en, e_do, e_pad, e_di, tb_val, tb_en;

  function automatic logic map_bit(input logic [1:0] md, input logic [3:0] oe, input int p);
    case (md)
      2'd0:    return oe[0];
      2'd1:    return (p < 4) ? oe[0] : oe[1];
      2'd2:    return oe[p / 2];
      default: return (p < 4) ? oe[p] : 1'b1;
    endcase
  endfunction

  always_comb begin
    for (int p = 0; p < 8; p++) begin
      m_map[p]  = map_bit(cfg_oe_mode, fab_oe, p);
      e_en[p]   = cfg_out_reg[p] ? m_eq[p] : m_map[p];
      e_do[p]   = cfg_out_reg[p] ? m_dq[p] : fab_do[p];
      tb_val[p] = ~e_do[p];
      tb_en[p]  = ~e_en[p];
      e_pad[p]  = e_en[p] ? e_do[p] : tb_val[p];
      e_di[p]   = cfg_in_sync[p] ? m_s2[p] : e_pad[p];
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_drv
    assign pad[g] = tb_en[g] ? tb_val[g] : 1'bz;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dq <= '0; m_eq <= '0; m_s1 <= '0; m_s2 <= '0; rel_cnt <= 0;
    end else if (rel_cnt < 2) begin
      rel_cnt <= rel_cnt + 1;
    end else begin
      for (int p = 0; p < 8; p++) begin
        if (cfg_out_reg[p]) begin
          m_dq[p] <= fab_do[p];
          m_eq[p] <= m_map[p];
        end
        if (cfg_in_sync[p]) begin
          m_s1[p] <= e_pad[p];
          m_s2[p] <= m_s1[p];
        end
      end
    end
  end

  // ---------------- comparison ----------------
  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'd0:    return "R6";
      2'd1:    return "R7";
      2'd2:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare_all();
    string t;
    for (int p = 0; p < 8; p++) begin
      n_cmp++;
      if (!rst_n) t = "R1";
      else if (!e_en[p]) t = "R10";
      else if (cfg_out_reg[p]) t = "R2";
      else t = "R3";
      if (pad[p] !== e_pad[p]) begin
        n_bad++;
        $display("FAIL %s %s pad[%0d] actual=%b expected=%b", t, mode_tag(cfg_oe_mode),
                 p, pad[p], e_pad[p]);
      end
      n_cmp++;
      if (!rst_n) t = "R1";
      else if (rel_cnt < 2) t = "R11";
      else if (cfg_in_sync[p]) t = "R4";
      else t = "R5";
      if (fab_di[p] !== e_di[p]) begin
        n_bad++;
        $display("FAIL %s fab_di[%0d] actual=%b expected=%b", t, p, fab_di[p], e_di[p]);
      end
    end
  endtask

  task automatic run_cycles(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_all();
      fab_do = 8'($urandom);
      fab_oe = 4'($urandom);
    end
  endtask

  // ---------------- stimulus ----------------
  logic done = 1'b0;

  initial begin
    rst_n = 1'b0;
    cfg_out_reg = 8'hFF; cfg_in_sync = 8'hFF; cfg_oe_mode = 2'd0;
    fab_do = 8'hFF; fab_oe = 4'hF;
    run_cycles(3);                       // R1: reset state under active inputs
    rst_n = 1'b1;
    run_cycles(5);                       // R11: release takes two edges
    for (int m = 0; m < 4; m++) begin
      cfg_oe_mode = 2'(m);
      cfg_out_reg = 8'h00; cfg_in_sync = 8'h00; run_cycles(30);  // R3 R5
      cfg_out_reg = 8'hFF; cfg_in_sync = 8'hFF; run_cycles(30);  // R2 R4
      cfg_out_reg = 8'h5A; cfg_in_sync = 8'hC3; run_cycles(30);  // mixed
      if (m == 2) begin
        @(negedge clk);
        #3 rst_n = 1'b0;                 // R1: asynchronous clear away from an edge
        run_cycles(3);
        #4 rst_n = 1'b1;
        run_cycles(6);                   // R11
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule